// File: doc/BRIEF.md
# Dual-Tap Odd/Even Line Reassembler

The block receives the digitized output of a linear image sensor whose charge is read through two taps at the same pixel rate. One tap carries the odd-numbered pixels of the line and the other carries the even-numbered ones. Both taps advance together, so a common valid strobe qualifies a pair of samples, and a line-start marker flags the first sample of each line. Each tap opens its line with a fixed run of dummy samples. The light-shielded part of that run gives the tap's black level. Everything that follows the active pixels carries no image and is discarded.

A parser state machine walks each line through named states. `P_IDLE` holds until the first marked sample. `P_HEAD` covers the isolation samples at the head of the line, `P_SHIELD` the shielded samples and `P_GAP` the isolation samples before the image. `P_ACTIVE` covers the image pairs and `P_TAIL` everything after them. A marked valid sample moves the machine to `P_HEAD` from any state. When the count in a state runs out, the machine goes HEAD→SHIELD→GAP→ACTIVE→TAIL. `P_TAIL` is left only by a new marker.

The averaged shielded level of each tap is subtracted from that tap's image samples, and the result is clamped at zero. A per-tap fixed-point gain is then applied, with rounding and saturation. The corrected pairs go into a buffer of pairs. An output state machine (`H_ODD`, then `H_EVEN`, then back) serializes each pair into one pixel stream in spatial order, using valid/ready handshaking and start/end-of-line flags.

Top module: `dual_tap_reassembler`

## Requirements
- R1: For each pair index k, the output gives the corrected odd-tap sample k and then the corrected even-tap sample k. Pairs leave in the order they arrived.
- R2: Samples produce no output in any of these cases: before the first marked sample, in the 23 leading samples of a line (5 isolation, 16 shielded, 2 isolation), and after the N/2-th image pair of a line.
- R3: The black level of a tap is the floor of the mean of its 16 shielded samples in the current line. An image sample at or below that level becomes 0. Otherwise the image sample is reduced by that level.
- R4: The gain is an unsigned GAIN_W-bit code with GAIN_W−1 fraction bits, so mid-code 2^(GAIN_W−1) means 1.0. The result is floor((d·g + 2^(GAIN_W−2)) / 2^(GAIN_W−1)), where d is the black-corrected sample and g the gain code. A result above 2^OUT_W−1 is saturated to that value.
- R5: `out_sol` is high only with pixel 1 of a line, and `out_eol` is high only with pixel N.
- R6: With the buffer empty, a pair taken at clock edge E is offered as the odd pixel after edge E+2. While `out_valid` is high and `out_ready` is low, the data and flags stay unchanged.
- R7: A cycle with `in_valid` low does not advance parsing, whatever the data or marker inputs carry.
- R8: A marked valid sample restarts parsing at any point and counts as the first head sample. Pairs already accepted are still delivered, and the abandoned line gets no end flag.
- R9: The buffer holds FIFO_DEPTH pairs. An image pair that arrives when the buffer is full and no pair leaves in the same cycle is dropped, and `overflow` then goes high and stays high until reset.
- R10: After reset, `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies one sample on each tap |
| in_start | input | 1 | Marks the first sample of a line |
| tap_odd | input | IN_W | Odd-pixel tap sample |
| tap_even | input | IN_W | Even-pixel tap sample |
| gain_odd | input | GAIN_W | Gain code for the odd tap |
| gain_even | input | GAIN_W | Gain code for the even tap |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_data | output | OUT_W | Corrected pixel |
| out_sol | output | 1 | First pixel of the line |
| out_eol | output | 1 | Last pixel of the line |
| overflow | output | 1 | Sticky flag for a pair dropped at a full buffer |

## Verification
An image pair captured at edge E is written to the buffer at edge E+2. Its two pixels are then offered, one pixel per handshake, whenever the consumer is ready. The bench model stamps each expected pixel with a due cycle of capture edge plus two. On every falling edge it compares `out_valid` with "the queue front is due". When both are valid it also compares data and flags. An accepted handshake on the rising edge removes one entry from the queue, so any cycle shift or reordering shows up at once.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

    typedef enum logic [2:0] {
        P_IDLE   = 3'd0,
        P_HEAD   = 3'd1,
        P_SHIELD = 3'd2,
        P_GAP    = 3'd3,
        P_ACTIVE = 3'd4,
        P_TAIL   = 3'd5
    } parse_state_t;

    typedef enum logic {
        H_ODD  = 1'b0,
        H_EVEN = 1'b1
    } half_t;

endpackage

// File: rtl/dtr_line_parser.sv
module dtr_line_parser
    import dtr_pkg::*;
#(
    parameter int ISO_HEAD = 5,
    parameter int SHIELD   = 16,
    parameter int ISO_GAP  = 2,
    parameter int PAIRS    = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    output logic sh_stb,
    output logic sh_first,
    output logic sh_last,
    output logic act_stb,
    output logic act_first,
    output logic act_last
);
    localparam int CNT_W = $clog2(ISO_HEAD + SHIELD + ISO_GAP + PAIRS + 1);

    parse_state_t state_q, state_n, eff_st;
    logic [CNT_W-1:0] cnt_q, cnt_n, eff_cnt;

    assign eff_st  = in_start ? P_HEAD : state_q;
    assign eff_cnt = in_start ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (in_valid) begin
            unique case (eff_st)
                P_IDLE: begin
                    state_n = P_IDLE;
                end
                P_HEAD: begin
                    if (eff_cnt == CNT_W'(ISO_HEAD - 1)) begin
                        state_n = P_SHIELD;
                        cnt_n   = '0;
                    end else begin
                        state_n = P_HEAD;
                        cnt_n   = eff_cnt + 1'b1;
                    end
                end
                P_SHIELD: begin
                    if (eff_cnt == CNT_W'(SHIELD - 1)) begin
                        state_n = P_GAP;
                        cnt_n   = '0;
                    end else begin
                        state_n = P_SHIELD;
                        cnt_n   = eff_cnt + 1'b1;
                    end
                end
                P_GAP: begin
                    if (eff_cnt == CNT_W'(ISO_GAP - 1)) begin
                        state_n = P_ACTIVE;
                        cnt_n   = '0;
                    end else begin
                        state_n = P_GAP;
                        cnt_n   = eff_cnt + 1'b1;
                    end
                end
                P_ACTIVE: begin
                    if (eff_cnt == CNT_W'(PAIRS - 1)) begin
                        state_n = P_TAIL;
                        cnt_n   = '0;
                    end else begin
                        state_n = P_ACTIVE;
                        cnt_n   = eff_cnt + 1'b1;
                    end
                end
                P_TAIL: begin
                    state_n = P_TAIL;
                end
                default: begin
                    state_n = P_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_comb begin
        sh_stb    = in_valid && (eff_st == P_SHIELD);
        sh_first  = (eff_cnt == '0);
        sh_last   = (eff_cnt == CNT_W'(SHIELD - 1));
        act_stb   = in_valid && (eff_st == P_ACTIVE);
        act_first = (eff_cnt == '0);
        act_last  = (eff_cnt == CNT_W'(PAIRS - 1));
    end

endmodule

// File: rtl/dtr_dark_acc.sv
module dtr_dark_acc #(
    parameter int IN_W   = 12,
    parameter int SHIELD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic            first,
    input  logic            last,
    input  logic [IN_W-1:0] smp,
    output logic [IN_W-1:0] dark
);
    localparam int SH_LOG = $clog2(SHIELD);
    localparam int ACC_W  = IN_W + SH_LOG;

    logic [ACC_W-1:0] acc_q, acc_sum;

    assign acc_sum = (first ? '0 : acc_q) + ACC_W'(smp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            dark  <= '0;
        end else if (stb) begin
            acc_q <= acc_sum;
            if (last) begin
                dark <= acc_sum[ACC_W-1:SH_LOG];
            end
        end
    end

endmodule

// File: rtl/dtr_tap_corr.sv
module dtr_tap_corr #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 12,
    parameter int GAIN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [IN_W-1:0]   smp,
    input  logic [IN_W-1:0]   dark,
    input  logic [GAIN_W-1:0] gain,
    output logic              pix_vld,
    output logic [OUT_W-1:0]  pix
);
    localparam int FRAC   = GAIN_W - 1;
    localparam int PROD_W = IN_W + GAIN_W;
    localparam logic [PROD_W-1:0] HALF   = PROD_W'(1) << (FRAC - 1);
    localparam logic [PROD_W-1:0] MAXOUT = (PROD_W'(1) << OUT_W) - PROD_W'(1);

    logic              s1_vld;
    logic [IN_W-1:0]   diff_q;
    logic [PROD_W-1:0] prod, scaled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            diff_q <= '0;
        end else begin
            s1_vld <= smp_stb;
            if (smp_stb) begin
                diff_q <= (smp > dark) ? (smp - dark) : '0;
            end
        end
    end

    assign prod   = PROD_W'(diff_q) * PROD_W'(gain) + HALF;
    assign scaled = prod >> FRAC;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_vld <= 1'b0;
            pix     <= '0;
        end else begin
            pix_vld <= s1_vld;
            if (s1_vld) begin
                pix <= (scaled > MAXOUT) ? MAXOUT[OUT_W-1:0] : scaled[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dtr_pair_fifo.sv
module dtr_pair_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                wdata,
    input  logic                        pop,
    output logic [W-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic             full, push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && (!full || pop_ok);
    assign head    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= '0;
            rd_q     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
            if (push && !push_ok) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_tap_reassembler.sv
module dual_tap_reassembler
    import dtr_pkg::*;
#(
    parameter int N_PIX      = 512,
    parameter int IN_W       = 12,
    parameter int OUT_W      = 12,
    parameter int GAIN_W     = 10,
    parameter int ISO_HEAD   = 5,
    parameter int SHIELD     = 16,
    parameter int ISO_GAP    = 2,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [IN_W-1:0]   tap_odd,
    input  logic [IN_W-1:0]   tap_even,
    input  logic [GAIN_W-1:0] gain_odd,
    input  logic [GAIN_W-1:0] gain_even,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_sol,
    output logic              out_eol,
    output logic              overflow
);
    localparam int PAIRS   = N_PIX / 2;
    localparam int ENTRY_W = 2 * OUT_W + 2;
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

    logic sh_stb, sh_first, sh_last, act_stb, act_first, act_last;
    logic [IN_W-1:0]   smp_a  [2];
    logic [GAIN_W-1:0] gain_a [2];
    logic [IN_W-1:0]   dark_a [2];
    logic [OUT_W-1:0]  pix_a  [2];
    logic              pvld_a [2];

    assign smp_a[0]  = tap_odd;
    assign smp_a[1]  = tap_even;
    assign gain_a[0] = gain_odd;
    assign gain_a[1] = gain_even;

    dtr_line_parser #(
        .ISO_HEAD(ISO_HEAD), .SHIELD(SHIELD), .ISO_GAP(ISO_GAP), .PAIRS(PAIRS)
    ) u_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .sh_stb(sh_stb), .sh_first(sh_first), .sh_last(sh_last),
        .act_stb(act_stb), .act_first(act_first), .act_last(act_last)
    );

    for (genvar gt = 0; gt < 2; gt++) begin : g_tap
        dtr_dark_acc #(.IN_W(IN_W), .SHIELD(SHIELD)) u_dark (
            .clk(clk), .rst_n(rst_n), .stb(sh_stb), .first(sh_first),
            .last(sh_last), .smp(smp_a[gt]), .dark(dark_a[gt])
        );
        dtr_tap_corr #(.IN_W(IN_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)) u_corr (
            .clk(clk), .rst_n(rst_n), .smp_stb(act_stb), .smp(smp_a[gt]),
            .dark(dark_a[gt]), .gain(gain_a[gt]),
            .pix_vld(pvld_a[gt]), .pix(pix_a[gt])
        );
    end

    // line-position flags travel alongside the two correction stages
    logic f1_first, f1_last, f2_first, f2_last;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f1_first <= 1'b0;
            f1_last  <= 1'b0;
            f2_first <= 1'b0;
            f2_last  <= 1'b0;
        end else begin
            f1_first <= act_stb && act_first;
            f1_last  <= act_stb && act_last;
            f2_first <= f1_first;
            f2_last  <= f1_last;
        end
    end

    logic               pair_push, pair_pop;
    logic [ENTRY_W-1:0] pair_w, pair_head;
    logic [CNT_W-1:0]   fifo_cnt;

    assign pair_push = pvld_a[0] && pvld_a[1];
    assign pair_w    = {f2_first, f2_last, pix_a[0], pix_a[1]};

    dtr_pair_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(pair_push), .wdata(pair_w),
        .pop(pair_pop), .head(pair_head), .count(fifo_cnt), .overflow(overflow)
    );

    half_t half_q, half_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= H_ODD;
        end else begin
            half_q <= half_n;
        end
    end

    always_comb begin
        out_valid = (fifo_cnt != '0);
        half_n    = half_q;
        pair_pop  = 1'b0;
        unique case (half_q)
            H_ODD: begin
                out_data = pair_head[2*OUT_W-1:OUT_W];
                out_sol  = pair_head[ENTRY_W-1];
                out_eol  = 1'b0;
                if (out_valid && out_ready) begin
                    half_n = H_EVEN;
                end
            end
            H_EVEN: begin
                out_data = pair_head[OUT_W-1:0];
                out_sol  = 1'b0;
                out_eol  = pair_head[ENTRY_W-2];
                if (out_valid && out_ready) begin
                    half_n   = H_ODD;
                    pair_pop = 1'b1;
                end
            end
            default: begin
                out_data = '0;
                out_sol  = 1'b0;
                out_eol  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
    parameter int OUT_W = 12,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [OUT_W-1:0]           out_data,
    input logic                       out_sol,
    input logic                       out_eol,
    input logic                       overflow,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_sol) && $stable(out_eol)); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(fifo_cnt) == CNT_W'(DEPTH)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH)); // R9

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sol && out_eol)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !overflow); // R10

endmodule

bind dual_tap_reassembler dtr_checker #(.OUT_W(OUT_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol),
    .overflow(overflow), .fifo_cnt(fifo_cnt)
);

// File: tb/dual_tap_reassembler_bench.sv
module dual_tap_reassembler_bench;
    localparam int NP    = 32;
    localparam int DEPTH = 8;
    localparam int LEAD  = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0;
    logic [11:0] tap_odd = '0, tap_even = '0;
    logic [9:0]  gain_odd = 10'd512, gain_even = 10'd512;
    logic out_valid, out_ready, out_sol, out_eol, overflow;
    logic [11:0] out_data;

    always #10 clk = ~clk;

    dual_tap_reassembler #(.N_PIX(NP), .FIFO_DEPTH(DEPTH)) u_dual_tap_reassembler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .tap_odd(tap_odd), .tap_even(tap_even), .gain_odd(gain_odd),
        .gain_even(gain_even), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol),
        .overflow(overflow)
    );

    typedef struct {int data; bit sol; bit eol; int avail;} exp_t;
    exp_t q[$];

    int cyc = 0, checks = 0, fails = 0;
    int rdy_mode = 0, sol_seen = 0, eol_seen = 0, hs_seen = 0;
    bit model_on = 1'b0, done = 1'b0;

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (model_on && q.size() > 0 && q[0].avail <= cyc && out_ready) void'(q.pop_front());
        if (rst_n && out_valid && out_ready) begin
            hs_seen++;
            if (out_sol) sol_seen++;
            if (out_eol) eol_seen++;
        end
        cyc++;
    end

    always @(negedge clk) begin
        out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 4) != 3) : 1'b0;
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            bit ev;
            ev = (q.size() > 0) && (q[0].avail <= cyc);
            check(out_valid == ev, "R6 valid timing", out_valid, ev);
            if (ev && out_valid) begin
                check(out_data == q[0].data, "R1/R3/R4 pixel value", out_data, q[0].data);
                check(out_sol == q[0].sol, "R5 sol", out_sol, q[0].sol);
                check(out_eol == q[0].eol, "R5 eol", out_eol, q[0].eol);
            end
            check(overflow == 1'b0, "R9 no overflow", overflow, 0);
        end
    end

    function automatic int corr(int s, int dk, int g);
        int d, y;
        d = (s > dk) ? s - dk : 0;
        y = (d * g + 256) >> 9;
        return (y > 4095) ? 4095 : y;
    endfunction

    function automatic int act_val(int k, int tap, int seed, int mode);
        int p;
        p = (seed * 37 + k * 131 + tap * 977) % 4096;
        if (mode == 1) return (k % 3 == 0) ? 10 : p % 2000;
        if (mode == 2) return 3000 + k * 30 + tap * 7;
        return p;
    endfunction

    task automatic send(bit v, bit st, int a, int b, bit gaps);
        @(negedge clk);
        in_valid = v; in_start = st; tap_odd = 12'(a); tap_even = 12'(b);
        if (gaps) begin
            @(negedge clk);
            in_valid = 1'b0; in_start = 1'b1; tap_odd = 12'hFFF; tap_even = 12'hFFF; // R7
        end
    endtask

    task automatic run_line(int dko, int dke, int seed, int mode, int npairs, int tail, bit gaps);
        int so = 0, se = 0, dark_o, dark_e;
        for (int i = 0; i < LEAD; i++) begin
            int a, b;
            if (i < 5) begin a = 3000 + i; b = 3100; end
            else if (i < 21) begin
                a = dko + (i % 4); b = dke + ((i + 1) % 4); so += a; se += b;
            end else begin a = 4000; b = 4000; end
            send(1'b1, i == 0, a, b, gaps);
        end
        dark_o = so / 16; dark_e = se / 16;
        for (int k = 0; k < npairs; k++) begin
            int a, b, av;
            exp_t e;
            a = act_val(k, 0, seed, mode); b = act_val(k, 1, seed, mode);
            @(negedge clk);
            in_valid = 1'b1; in_start = 1'b0; tap_odd = 12'(a); tap_even = 12'(b);
            av = cyc + 3;
            e.data = corr(a, dark_o, gain_odd); e.sol = (k == 0); e.eol = 1'b0; e.avail = av;
            q.push_back(e);
            e.data = corr(b, dark_e, gain_even); e.sol = 1'b0; e.eol = (k == NP/2 - 1);
            q.push_back(e);
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0; in_start = 1'b1; tap_odd = 12'hFFF; tap_even = 12'hFFF;
            end
        end
        for (int t = 0; t < tail; t++) send(1'b1, 1'b0, 4095, 4095, gaps);
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
    endtask

    task automatic drain(string req);
        for (int w = 0; w < 400 && q.size() > 0; w++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(q.size() == 0 && out_valid == 1'b0, req, out_valid, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; model_on = 1'b0; in_valid = 1'b0; in_start = 1'b0;
        q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
            finish_run();
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
        check(overflow == 1'b0, "R10 reset overflow", overflow, 0);
        model_on = 1'b1;

        // R2: samples before any line marker produce nothing
        for (int i = 0; i < 40; i++) send(1'b1, 1'b0, 100 + i, 200 + i, 1'b0);
        @(negedge clk); in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R2 stray samples", out_valid, 0);

        // R1 R3 R5: unity gain, full line
        sol_seen = 0; eol_seen = 0; hs_seen = 0;
        gain_odd = 10'd512; gain_even = 10'd512; rdy_mode = 0;
        run_line(60, 90, 3, 0, NP/2, 12, 1'b1);
        drain("R2 leftover after line");
        check(hs_seen == NP, "R2 pixel count", hs_seen, NP);
        check(sol_seen == 1, "R5 sol count", sol_seen, 1);
        check(eol_seen == 1, "R5 eol count", eol_seen, 1);

        // R3 clamp, R4 gains at +/-15%, R6 stalls
        gain_odd = 10'd589; gain_even = 10'd435; rdy_mode = 1;
        run_line(64, 40, 7, 1, NP/2, 9, 1'b1);
        drain("R6 leftover after stalled line");

        // R4 saturation
        gain_odd = 10'd1023; gain_even = 10'd512; rdy_mode = 0;
        run_line(50, 50, 11, 2, NP/2, 5, 1'b1);
        drain("R4 leftover after bright line");

        // R8: abandoned line, then a full one
        sol_seen = 0; eol_seen = 0;
        gain_odd = 10'd512; gain_even = 10'd560; rdy_mode = 1;
        run_line(30, 70, 19, 0, 5, 0, 1'b1);
        run_line(80, 20, 23, 0, NP/2, 4, 1'b1);
        drain("R8 leftover after restart");
        check(sol_seen == 2, "R8 sol count", sol_seen, 2);
        check(eol_seen == 1, "R8 eol count", eol_seen, 1);

        // R9: consumer stalled, back-to-back pairs overrun the buffer
        model_on = 1'b0; rdy_mode = 2;
        run_line(10, 10, 5, 0, NP/2, 2, 1'b0);
        repeat (6) @(negedge clk);
        check(overflow == 1'b1, "R9 overflow raised", overflow, 1);
        check(out_valid == 1'b1, "R9 buffer held", out_valid, 1);
        repeat (4) @(negedge clk);
        check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

        rdy_mode = 0;
        do_reset();
        @(negedge clk);
        check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
        check(out_valid == 1'b0, "R10 valid cleared", out_valid, 0);

        done = 1'b1;
        finish_run();
    end
endmodule